// File: doc/BRIEF.md
# GPIO Controller with Per-Pin Interrupts

This block drives and samples up to 32 general-purpose pins and raises interrupts from them. Software reaches it over a simple word-addressed register bus. Each pin has its own configuration word. That word sets the output drive, the output buffer, input sampling, the interrupt enable and one of five interrupt kinds: rising edge, falling edge, both edges, level high or level low.

Pad inputs first pass through a two-flop synchroniser. Detected events land in a shared pending register, and software clears that register one bit at a time by writing ones to it. A single interrupt line goes to the parent interrupt controller. It is asserted while any pending pin also has its interrupt enabled.

To mask a pin, the driver clears the enable bit. To unmask it, the driver first writes the word with input mode on and then sets the enable bit.

Top module: `gpio_irq_ctrl`

## Requirements
- R1: After reset, every pin configuration word, the output data word and the pending word are zero, and rdata_o, pad_oe_o, pad_o and irq_o are all zero.
- R2: The register map uses word index addr_i[7:2]. Words 0 to 31 hold the configuration word of the pin with that number. Its bit 0 is output enable, bit 1 is input enable, bit 2 is buffer enable, bit 3 is interrupt enable and bits 7:5 are the interrupt kind. All other bits read back as zero. Word 32 (byte 0x80) is the pending word, word 33 (0x84) is the input word and word 34 (0x88) is the output data word. Any other word reads as zero.
- R3: A read request returns its data on rdata_o from the clock edge that accepts it. rdata_o then holds that value until the next read is accepted.
- R4: pad_o drives the output data word. pad_oe_o for a pin is high only when both its output enable bit and its buffer enable bit are set.
- R5: Pad inputs pass through two flip-flops. The input word shows the synchronised value only for pins whose input enable is set, and reads zero for the others. A pin whose input enable is clear never raises an event.
- R6: Kind code 2 (rising), 3 (falling) and 4 (both edges) set the pin's pending bit once per matching edge of the synchronised input. The bit then stays set until software clears it.
- R7: Kind code 0 (level high) and 1 (level low) raise an event on every cycle the level is present. A clear issued while the level is still present therefore leaves the bit set.
- R8: Kind codes 5, 6 and 7 never raise an event.
- R9: A write to the pending word clears each bit written as one and leaves each bit written as zero unchanged. If an event hits a pin in the same cycle as its clear, the event wins and the bit stays set.
- R10: irq_o is the OR of the pending bits whose pin has its interrupt enable set. A pending bit on a pin whose interrupt enable is clear is still latched and readable, but it does not drive irq_o.

## Ports
| Port | Direction | Width | Description |
|------|-----------|-------|-------------|
| clk_i | input | 1 | Clock |
| rst_ni | input | 1 | Asynchronous reset, active low |
| req_i | input | 1 | Bus request for one cycle |
| we_i | input | 1 | Write when high, read when low |
| addr_i | input | ADDR_W | Byte address; bits 1:0 are ignored |
| wdata_i | input | 32 | Write data |
| rdata_o | output | 32 | Read data, registered |
| pad_i | input | NUM_PINS | Pad input levels, asynchronous |
| pad_o | output | NUM_PINS | Pad output values |
| pad_oe_o | output | NUM_PINS | Pad output enables |
| irq_o | output | 1 | Aggregated interrupt to the parent controller |

## Verification
The assertions check four things on every cycle. A rising-kind event only follows a low-to-high step of the synchronised input. The reserved kind codes stay silent. A clear with no concurrent event empties the bit, while a concurrent event leaves it set. rdata_o holds steady between reads.

Other behaviours can only be shown by the bench scenarios:
- each interrupt kind and its response timing;
- masking of input-disabled pins;
- gating of irq_o by the enable bits;
- the bit layout of the configuration words;
- the race in which a clear and an event land in the same cycle, which the bench places by counting the synchroniser stages.

// File: rtl/gpio_irq_pkg.sv
`timescale 1ns/1ps
package gpio_irq_pkg;

  typedef enum logic [2:0] {
    IRQ_LVL_HI = 3'd0,
    IRQ_LVL_LO = 3'd1,
    IRQ_RISE   = 3'd2,
    IRQ_FALL   = 3'd3,
    IRQ_BOTH   = 3'd4
  } irq_kind_e;

  typedef struct packed {
    logic [2:0] kind;
    logic       irq_en;
    logic       buf_en;
    logic       in_en;
    logic       out_en;
  } pin_cfg_t;

  localparam int STAT_WORD = 32;
  localparam int IN_WORD   = 33;
  localparam int OUT_WORD  = 34;

  function automatic logic [31:0] cfg_to_word(pin_cfg_t c);
    return {24'd0, c.kind, 1'b0, c.irq_en, c.buf_en, c.in_en, c.out_en};
  endfunction

  function automatic pin_cfg_t word_to_cfg(logic [31:0] w);
    pin_cfg_t c;
    c.out_en = w[0];
    c.in_en  = w[1];
    c.buf_en = w[2];
    c.irq_en = w[3];
    c.kind   = w[7:5];
    return c;
  endfunction

endpackage

// File: rtl/gpio_sync.sv
`timescale 1ns/1ps
module gpio_sync #(
  parameter int WIDTH = 32
) (
  input  logic             clk_i,
  input  logic             rst_ni,
  input  logic [WIDTH-1:0] d_i,
  output logic [WIDTH-1:0] q_o
);
  logic [WIDTH-1:0] meta_q, sync_q;

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni) begin
      meta_q <= '0;
      sync_q <= '0;
    end else begin
      meta_q <= d_i;
      sync_q <= meta_q;
    end
  end

  assign q_o = sync_q;
endmodule

// File: rtl/gpio_evt_det.sv
`timescale 1ns/1ps
module gpio_evt_det
  import gpio_irq_pkg::*;
(
  input  logic       clk_i,
  input  logic       rst_ni,
  input  logic       lvl_i,
  input  logic       en_i,
  input  logic [2:0] kind_i,
  output logic       evt_o
);
  logic prev_q;
  logic hit;

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni) prev_q <= 1'b0;
    else         prev_q <= lvl_i;
  end

  always_comb begin
    case (kind_i)
      IRQ_LVL_HI: hit = lvl_i;
      IRQ_LVL_LO: hit = ~lvl_i;
      IRQ_RISE:   hit = lvl_i & ~prev_q;
      IRQ_FALL:   hit = ~lvl_i & prev_q;
      IRQ_BOTH:   hit = lvl_i ^ prev_q;
      default:    hit = 1'b0;
    endcase
  end

  assign evt_o = en_i & hit;

  // R6: a rising-kind event must follow a real low-to-high step
  a_r6_rise_step: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (kind_i == IRQ_RISE && evt_o) |-> (lvl_i && !$past(lvl_i)));

  // R8: reserved kinds stay silent
  a_r8_reserved_quiet: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (kind_i > 3'd4) |-> !evt_o);
endmodule

// File: rtl/gpio_irq_ctrl.sv
`timescale 1ns/1ps
module gpio_irq_ctrl
  import gpio_irq_pkg::*;
#(
  parameter int NUM_PINS = 32,
  parameter int ADDR_W   = 8
) (
  input  logic                clk_i,
  input  logic                rst_ni,
  input  logic                req_i,
  input  logic                we_i,
  input  logic [ADDR_W-1:0]   addr_i,
  input  logic [31:0]         wdata_i,
  output logic [31:0]         rdata_o,
  input  logic [NUM_PINS-1:0] pad_i,
  output logic [NUM_PINS-1:0] pad_o,
  output logic [NUM_PINS-1:0] pad_oe_o,
  output logic                irq_o
);
  localparam int WORD_W = ADDR_W - 2;

  logic [WORD_W-1:0]   word_idx;
  logic                wr_en, rd_en;
  pin_cfg_t            cfg_q [NUM_PINS];
  logic [NUM_PINS-1:0] out_q, pend_q, sync_w, in_vis, evt, clr, irq_en_vec;
  logic [31:0]         rd_mux, rdata_q;

  assign word_idx = addr_i[ADDR_W-1:2];
  assign wr_en    = req_i & we_i;
  assign rd_en    = req_i & ~we_i;

  gpio_sync #(.WIDTH(NUM_PINS)) u_sync (
    .clk_i (clk_i),
    .rst_ni(rst_ni),
    .d_i   (pad_i),
    .q_o   (sync_w)
  );

  // config and output data registers
  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni) begin
      for (int k = 0; k < NUM_PINS; k++) cfg_q[k] <= '0;
      out_q <= '0;
    end else if (wr_en) begin
      for (int k = 0; k < NUM_PINS; k++)
        if (word_idx == WORD_W'(k)) cfg_q[k] <= word_to_cfg(wdata_i);
      if (word_idx == WORD_W'(OUT_WORD)) out_q <= wdata_i[NUM_PINS-1:0];
    end
  end

  always_comb begin
    for (int k = 0; k < NUM_PINS; k++) begin
      in_vis[k]     = sync_w[k] & cfg_q[k].in_en;
      pad_oe_o[k]   = cfg_q[k].out_en & cfg_q[k].buf_en;
      irq_en_vec[k] = cfg_q[k].irq_en;
    end
  end

  assign pad_o = out_q;

  generate
    for (genvar i = 0; i < NUM_PINS; i++) begin : g_pin
      gpio_evt_det u_det (
        .clk_i (clk_i),
        .rst_ni(rst_ni),
        .lvl_i (sync_w[i]),
        .en_i  (cfg_q[i].in_en),
        .kind_i(cfg_q[i].kind),
        .evt_o (evt[i])
      );

      // R9: plain clear empties the bit
      a_r9_clear_empties: assert property (@(posedge clk_i) disable iff (!rst_ni)
        (clr[i] && !evt[i]) |=> !pend_q[i]);

      // R9: an event always leaves the bit set, even against a clear
      a_r9_event_wins: assert property (@(posedge clk_i) disable iff (!rst_ni)
        evt[i] |=> pend_q[i]);
    end
  endgenerate

  // write-one-to-clear pending; a new event has priority
  assign clr = (wr_en && word_idx == WORD_W'(STAT_WORD)) ? wdata_i[NUM_PINS-1:0] : '0;

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni) pend_q <= '0;
    else         pend_q <= (pend_q & ~clr) | evt;
  end

  assign irq_o = |(pend_q & irq_en_vec);

  always_comb begin
    rd_mux = '0;
    for (int k = 0; k < NUM_PINS; k++)
      if (word_idx == WORD_W'(k)) rd_mux = cfg_to_word(cfg_q[k]);
    if (word_idx == WORD_W'(STAT_WORD)) rd_mux = 32'(pend_q);
    if (word_idx == WORD_W'(IN_WORD))   rd_mux = 32'(in_vis);
    if (word_idx == WORD_W'(OUT_WORD))  rd_mux = 32'(out_q);
  end

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni)    rdata_q <= '0;
    else if (rd_en) rdata_q <= rd_mux;
  end

  assign rdata_o = rdata_q;

  // R3: read data holds between reads
  a_r3_rdata_hold: assert property (@(posedge clk_i) disable iff (!rst_ni)
    !rd_en |=> $stable(rdata_o));
endmodule

// File: tb/tb_gpio_irq_ctrl.sv
`timescale 1ns/1ps
module tb_gpio_irq_ctrl;
  localparam int N = 32;

  logic         clk_i = 1'b0;
  logic         rst_ni = 1'b0;
  logic         req_i = 1'b0;
  logic         we_i = 1'b0;
  logic [7:0]   addr_i = '0;
  logic [31:0]  wdata_i = '0;
  logic [31:0]  rdata_o;
  logic [N-1:0] pad_i = 32'h0000_0010;
  logic [N-1:0] pad_o, pad_oe_o;
  logic         irq_o;

  int checks = 0;
  int errors = 0;
  bit done = 1'b0;
  logic [31:0] exp_val_q[$];
  string       exp_tag_q[$];

  always #2.5 clk_i = ~clk_i;

  gpio_irq_ctrl #(.NUM_PINS(N), .ADDR_W(8)) dut (
    .clk_i(clk_i), .rst_ni(rst_ni), .req_i(req_i), .we_i(we_i),
    .addr_i(addr_i), .wdata_i(wdata_i), .rdata_o(rdata_o),
    .pad_i(pad_i), .pad_o(pad_o), .pad_oe_o(pad_oe_o), .irq_o(irq_o)
  );

  task automatic check(string tag, logic [31:0] act, logic [31:0] exp);
    checks++;
    if (act !== exp) begin
      errors++;
      $display("FAIL %s actual %h expected %h", tag, act, exp);
    end
  endtask

  task automatic cyc(int n);
    repeat (n) begin @(posedge clk_i); @(negedge clk_i); end
  endtask

  task automatic wr(logic [7:0] a, logic [31:0] d);
    req_i = 1'b1; we_i = 1'b1; addr_i = a; wdata_i = d;
    @(posedge clk_i); @(negedge clk_i);
    req_i = 1'b0; we_i = 1'b0;
  endtask

  // driver: queue the expectation, then issue the read
  task automatic rd(logic [7:0] a, logic [31:0] exp, string tag);
    exp_val_q.push_back(exp);
    exp_tag_q.push_back(tag);
    req_i = 1'b1; we_i = 1'b0; addr_i = a;
    @(posedge clk_i); @(negedge clk_i);
    req_i = 1'b0;
  endtask

  // monitor: compare each read result as it appears
  initial begin
    forever begin
      @(posedge clk_i);
      if (rst_ni && req_i && !we_i) begin
        @(negedge clk_i);
        if (exp_val_q.size() == 0) begin
          checks++; errors++;
          $display("FAIL scoreboard unexpected read actual %h expected none", rdata_o);
        end else begin
          check(exp_tag_q.pop_front(), rdata_o, exp_val_q.pop_front());
        end
      end
    end
  end

  initial begin
    repeat (20000) @(posedge clk_i);
    if (!done) begin
      checks++; errors++;
      $display("FAIL watchdog actual hung expected finish");
      $display("CHECKS %0d ERRORS %0d", checks, errors);
      $finish;
    end
  end

  initial begin
    cyc(3);
    rst_ni = 1'b1;
    cyc(1);
    check("R1 pad_oe", 32'(pad_oe_o), 32'h0);
    check("R1 pad_o", 32'(pad_o), 32'h0);
    check("R1 irq", 32'(irq_o), 32'h0);
    check("R1 rdata", rdata_o, 32'h0);
    rd(8'h80, 32'h0, "R1 pending");
    rd(8'h00, 32'h0, "R1 cfg0");

    // configuration
    wr(8'h00, 32'h4A);  // pin0 rise, in, irq
    wr(8'h04, 32'h6A);  // pin1 fall
    wr(8'h08, 32'h8A);  // pin2 both
    wr(8'h0C, 32'h0A);  // pin3 level high
    wr(8'h10, 32'h2A);  // pin4 level low
    wr(8'h14, 32'hCA);  // pin5 kind 6
    wr(8'h18, 32'h42);  // pin6 rise, irq disabled
    wr(8'h1C, 32'hFFFF_FFFF); // pin7 all, kind 7
    wr(8'h20, 32'h01);  // pin8 out only
    wr(8'h7C, 32'h28);  // pin31 level low, input off
    wr(8'h88, 32'h80);
    rd(8'h1C, 32'hEF, "R2 cfg7 layout");
    rd(8'h04, 32'h6A, "R2 cfg1 readback");
    rd(8'hFC, 32'h0, "R2 unmapped");
    rd(8'h88, 32'h80, "R2 out data");
    check("R4 pad_oe", 32'(pad_oe_o), 32'h80);
    check("R4 pad_o", 32'(pad_o), 32'h80);
    cyc(4);
    rd(8'h80, 32'h0, "R5 idle pending, pin31 disabled");
    check("R3 rdata held", rdata_o, 32'h0);
    pad_i[31] = 1'b1;
    cyc(4);
    rd(8'h84, 32'h10, "R5 input word masked");

    // R10: pending without enable
    pad_i[6] = 1'b1; cyc(4);
    rd(8'h80, 32'h40, "R10 pending latched");
    check("R10 irq gated", 32'(irq_o), 32'h0);
    // R6 rise
    pad_i[0] = 1'b1; cyc(4);
    rd(8'h80, 32'h41, "R6 rise");
    check("R10 irq asserted", 32'(irq_o), 32'h1);
    wr(8'h80, 32'h41);
    rd(8'h80, 32'h0, "R9 clear");
    check("R10 irq after clear", 32'(irq_o), 32'h0);
    // R6 fall
    pad_i[1] = 1'b1; cyc(4);
    rd(8'h80, 32'h0, "R6 fall ignores rise");
    pad_i[1] = 1'b0; cyc(4);
    rd(8'h80, 32'h2, "R6 fall");
    wr(8'h80, 32'h2);
    // R6 both
    pad_i[2] = 1'b1; cyc(4);
    rd(8'h80, 32'h4, "R6 both rise");
    wr(8'h80, 32'h4);
    pad_i[2] = 1'b0; cyc(4);
    rd(8'h80, 32'h4, "R6 both fall");
    wr(8'h80, 32'h4);
    // R7 level high
    pad_i[3] = 1'b1; cyc(4);
    rd(8'h80, 32'h8, "R7 level high");
    wr(8'h80, 32'h8);
    rd(8'h80, 32'h8, "R7 clear while held");
    pad_i[3] = 1'b0; cyc(4);
    wr(8'h80, 32'h8);
    rd(8'h80, 32'h0, "R7 clear after release");
    // R7 level low
    pad_i[4] = 1'b0; cyc(4);
    rd(8'h80, 32'h10, "R7 level low");
    pad_i[4] = 1'b1; cyc(4);
    wr(8'h80, 32'h10);
    rd(8'h80, 32'h0, "R7 level low cleared");
    // R8 reserved kinds
    pad_i[5] = 1'b1; pad_i[7] = 1'b1; cyc(4);
    pad_i[5] = 1'b0; pad_i[7] = 1'b0; cyc(4);
    rd(8'h80, 32'h0, "R8 reserved kinds");
    // R9 clear of zero bits leaves others
    pad_i[0] = 1'b0; cyc(4);
    pad_i[0] = 1'b1; cyc(4);
    wr(8'h80, 32'h2);
    rd(8'h80, 32'h1, "R9 zero bits untouched");
    // R9 event and clear in the same cycle
    pad_i[0] = 1'b0; cyc(4);
    pad_i[0] = 1'b1;
    cyc(2);
    wr(8'h80, 32'h1);
    rd(8'h80, 32'h1, "R9 event wins");
    wr(8'h80, 32'h1);
    rd(8'h80, 32'h0, "R9 final clear");
    cyc(2);

    done = 1'b1;
    $display("CHECKS %0d ERRORS %0d", checks, errors);
    $finish;
  end
endmodule